// File: doc/BRIEF.md
# JTAG Host Scan Engine

This block drives a JTAG chain as its master. It generates TCK from the system clock and drives TMS and TDI. It samples TDO and returns the bits shifted out during a scan. A controller hands it one command at a time. There are three commands: return the chain to Test-Logic-Reset and park it in Run-Test/Idle, scan the instruction path, or scan the data path. A scan command carries a bit count from 1 to 64 and a transmit word. When the walk back to Run-Test/Idle is complete, the block raises a one-cycle done pulse. The received word is then valid on `rx_data`.

The sequencer is a single enumerated state machine. Each state stands for one TCK slot and fixes the TMS level for that slot. The states are:

- `ST_IDLE`: waiting for a command.
- `ST_TLR`: TMS high, repeated for the reset count.
- `ST_SETTLE`: TMS low, lands the chain in Run-Test/Idle.
- `ST_SEL_DR`: TMS high.
- `ST_SEL_IR`: TMS high, used by instruction scans only.
- `ST_CAPTURE`: TMS low.
- `ST_ENTER_SHIFT`: TMS low.
- `ST_SHIFT`: TMS low, then high on the final bit.
- `ST_EXIT_UPD`: TMS high.
- `ST_BACK_IDLE`: TMS low.
- `ST_DONE`: the one-cycle done state.

The transitions are:

- From `ST_IDLE` or `ST_DONE`, an accepted command goes to `ST_TLR` (reset command) or to `ST_SEL_DR` (scan command). `ST_DONE` with no command returns to `ST_IDLE`.
- `ST_TLR` goes to `ST_SETTLE` after the last reset slot, and `ST_SETTLE` goes to `ST_DONE`.
- `ST_SEL_DR` goes to `ST_SEL_IR` for an instruction scan and to `ST_CAPTURE` for a data scan. `ST_SEL_IR` goes to `ST_CAPTURE`.
- `ST_CAPTURE` goes to `ST_ENTER_SHIFT`, which goes to `ST_SHIFT`.
- `ST_SHIFT` stays in place until its final bit, then goes to `ST_EXIT_UPD`.
- `ST_EXIT_UPD` goes to `ST_BACK_IDLE`, which goes to `ST_DONE`.

Every slot state except `ST_SHIFT` advances on a TCK falling edge.

Top module: `jscan_engine`

## Requirements
- R1: After reset, `busy`, `done`, `tck`, `tms` and `tdi` are low and `rx_data` is zero.
- R2: A command is taken when `cmd_valid` is high while `busy` is low, and `busy` is high from the next cycle until `done`. A `cmd_valid` pulse while `busy` is high has no effect: it produces no extra done pulse and leaves the chain state unchanged.
- R3: TCK toggles every HALF_DIV system clocks, so its period is 2*HALF_DIV clocks. TCK stays low whenever `busy` is low.
- R4: TMS and TDI change only at TCK falling edges or while TCK is low. TDO is sampled at each TCK rising edge.
- R5: `cmd_op` = 0 (reset) drives TMS high for RESET_CYCLES (at least 5) rising edges, then low for one. This leaves every device in Run-Test/Idle with its identification register selected.
- R6: `cmd_op` = 1 (instruction scan) walks TMS 1,1,0,0 from Run-Test/Idle into Shift-IR.
- R7: `cmd_op` = 2 (data scan) walks TMS 1,0,0 into Shift-DR. `cmd_op` = 3 behaves exactly as 2.
- R8: A scan shifts exactly `cmd_len` bits, with TMS high on the last of them, and then returns with TMS 1,0 through Update to Run-Test/Idle. A `cmd_len` of 0 means 64 bits.
- R9: Transmit bits leave on TDI least significant first. The first TDO bit lands in `rx_data` bit 0, and bits at or above `cmd_len` read zero.
- R10: On a chain of n devices that bypass, the data path is n bits long. After a reset command, a 64-bit data scan returns the two 32-bit identifiers concatenated, with the device nearest TDO in the low half.
- R11: `done` is high for exactly one cycle, with `busy` low. `rx_data` holds its value from then until the next command is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 reset, 1 instruction scan, 2 or 3 data scan |
| cmd_len | input | 7 | Scan bit count 1..64, 0 means 64 |
| cmd_tx | input | 64 | Transmit word, bit 0 sent first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 64 | Received word, bit 0 received first |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
The hardest case to reach from the ports is a length-dependent error that only shows across several chained devices. Examples are a dropped first bit after Capture-to-Shift, or a last bit clocked with TMS low. The bench places a two-device TAP model behind the engine and moves it through bypass and identification selections by loading instruction patterns. The model only returns to Run-Test/Idle, and bypass or identification data only arrives at the expected offsets, when every TMS slot and every shift bit lands on the right edge. A command pulse injected in the middle of a scan exercises the ignore path. The bench then checks that the chain's instruction state survives.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    typedef enum logic [1:0] {
        OP_RESET  = 2'd0,
        OP_IR     = 2'd1,
        OP_DR     = 2'd2,
        OP_DR_ALT = 2'd3
    } jscan_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TLR,
        ST_SETTLE,
        ST_SEL_DR,
        ST_SEL_IR,
        ST_CAPTURE,
        ST_ENTER_SHIFT,
        ST_SHIFT,
        ST_EXIT_UPD,
        ST_BACK_IDLE,
        ST_DONE
    } jscan_state_e;

endpackage

// File: rtl/jscan_tick_gen.sv
module jscan_tick_gen #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          edge_now;

    assign edge_now = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_stb = edge_now && !tck;
    assign fall_stb = edge_now && tck;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            tck <= 1'b0;
        end else if (edge_now) begin
            cnt <= '0;
            tck <= ~tck;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/jscan_shifter.sv
module jscan_shifter #(
    parameter int MAX_LEN = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [MAX_LEN-1:0]         tx_in,
    input  logic [$clog2(MAX_LEN)-1:0] last_in,
    input  logic                       sample,
    input  logic                       advance,
    input  logic                       tdo,
    output logic                       tdi,
    output logic                       is_last,
    output logic [MAX_LEN-1:0]         rx_out
);
    localparam int IDX_W = $clog2(MAX_LEN);

    logic [MAX_LEN-1:0] tx_sr;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   last_idx;

    assign tdi     = tx_sr[0];
    assign is_last = (idx == last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            rx_out   <= '0;
            idx      <= '0;
            last_idx <= '0;
        end else if (load) begin
            tx_sr    <= tx_in;
            rx_out   <= '0;
            idx      <= '0;
            last_idx <= last_in;
        end else begin
            if (sample) begin
                rx_out[idx] <= tdo;
            end
            if (advance) begin
                tx_sr <= tx_sr >> 1;
                idx   <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/jscan_engine.sv
module jscan_engine
    import jscan_pkg::*;
#(
    parameter int MAX_LEN      = 64,
    parameter int HALF_DIV     = 3,
    parameter int RESET_CYCLES = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_op,
    input  logic [$clog2(MAX_LEN+1)-1:0] cmd_len,
    input  logic [MAX_LEN-1:0]           cmd_tx,
    output logic                         busy,
    output logic                         done,
    output logic [MAX_LEN-1:0]           rx_data,
    output logic                         tck,
    output logic                         tms,
    output logic                         tdi,
    input  logic                         tdo
);
    localparam int IDX_W = $clog2(MAX_LEN);
    localparam int TW    = $clog2(RESET_CYCLES + 1);

    jscan_state_e   state, nxt;
    logic           accept;
    logic           scan_ir;
    logic [TW-1:0]  tlr_cnt;
    logic           rise_stb, fall_stb;
    logic           is_last;
    logic           in_shift;

    assign accept   = cmd_valid && !busy;
    assign in_shift = (state == ST_SHIFT);

    jscan_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .tck      (tck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    jscan_shifter #(.MAX_LEN(MAX_LEN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .tx_in    (cmd_tx),
        .last_in  (IDX_W'(cmd_len - 1'b1)),
        .sample   (rise_stb && in_shift),
        .advance  (fall_stb && in_shift && !is_last),
        .tdo      (tdo),
        .tdi      (tdi),
        .is_last  (is_last),
        .rx_out   (rx_data)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    nxt = (jscan_op_e'(cmd_op) == OP_RESET) ? ST_TLR : ST_SEL_DR;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_TLR:         if (fall_stb && tlr_cnt == TW'(RESET_CYCLES - 1)) nxt = ST_SETTLE;
            ST_SETTLE:      if (fall_stb) nxt = ST_DONE;
            ST_SEL_DR:      if (fall_stb) nxt = scan_ir ? ST_SEL_IR : ST_CAPTURE;
            ST_SEL_IR:      if (fall_stb) nxt = ST_CAPTURE;
            ST_CAPTURE:     if (fall_stb) nxt = ST_ENTER_SHIFT;
            ST_ENTER_SHIFT: if (fall_stb) nxt = ST_SHIFT;
            ST_SHIFT:       if (fall_stb && is_last) nxt = ST_EXIT_UPD;
            ST_EXIT_UPD:    if (fall_stb) nxt = ST_BACK_IDLE;
            ST_BACK_IDLE:   if (fall_stb) nxt = ST_DONE;
            default:        nxt = ST_IDLE;
        endcase
    end

    // state register and per-command bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            scan_ir <= 1'b0;
            tlr_cnt <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                scan_ir <= (jscan_op_e'(cmd_op) == OP_IR);
                tlr_cnt <= '0;
            end else if (state == ST_TLR && fall_stb) begin
                tlr_cnt <= tlr_cnt + TW'(1);
            end
        end
    end

    // outputs decoded from the slot state
    always_comb begin
        busy = 1'b1;
        done = 1'b0;
        tms  = 1'b0;
        unique case (state)
            ST_IDLE:        busy = 1'b0;
            ST_DONE:        begin busy = 1'b0; done = 1'b1; end
            ST_TLR:         tms = 1'b1;
            ST_SEL_DR:      tms = 1'b1;
            ST_SEL_IR:      tms = 1'b1;
            ST_SHIFT:       tms = is_last;
            ST_EXIT_UPD:    tms = 1'b1;
            ST_SETTLE, ST_CAPTURE, ST_ENTER_SHIFT, ST_BACK_IDLE: tms = 1'b0;
            default:        tms = 1'b0;
        endcase
    end
endmodule

// File: rtl/jscan_engine_chk.sv
module jscan_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic tck,
    input logic tms,
    input logic tdi
);
    // R2: a taken command makes the block busy on the next cycle
    a_r2_take_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R3: the test clock never runs while idle
    a_r3_tck_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    a_r3_tck_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> busy);

    // R4: TMS and TDI hold while TCK is high
    a_r4_tms_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> $stable(tms));

    a_r4_tdi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> $stable(tdi));

    // R11: done is a single-cycle pulse with busy low
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind jscan_engine jscan_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .tck       (tck),
    .tms       (tms),
    .tdi       (tdi)
);

// File: tb/jscan_engine_test.sv
module jscan_engine_test;
    localparam int HALF = 2;
    localparam logic [31:0] ID0 = 32'h3BA00477;  // device nearest TDO
    localparam logic [31:0] ID1 = 32'h16410041;
    localparam logic [3:0]  IR_ID  = 4'b1110;
    localparam logic [3:0]  IR_BYP = 4'b1111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [6:0]  cmd_len = 7'd0;
    logic [63:0] cmd_tx = '0;
    logic        busy, done, tck, tms, tdi;
    logic [63:0] rx_data;
    logic        tdo_m = 1'b0;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    jscan_engine #(.MAX_LEN(64), .HALF_DIV(HALF), .RESET_CYCLES(5)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .cmd_tx(cmd_tx), .busy(busy), .done(done),
        .rx_data(rx_data), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo_m)
    );

    // ---------------- two-device TAP model ----------------
    typedef enum int {T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR,
                      T_UPDDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPDIR} tap_e;

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR:   return m ? T_TLR   : T_RTI;
            T_RTI:   return m ? T_SELDR : T_RTI;
            T_SELDR: return m ? T_SELIR : T_CAPDR;
            T_CAPDR: return m ? T_EX1DR : T_SHDR;
            T_SHDR:  return m ? T_EX1DR : T_SHDR;
            T_EX1DR: return m ? T_UPDDR : T_PAUDR;
            T_PAUDR: return m ? T_EX2DR : T_PAUDR;
            T_EX2DR: return m ? T_UPDDR : T_SHDR;
            T_UPDDR: return m ? T_SELDR : T_RTI;
            T_SELIR: return m ? T_TLR   : T_CAPIR;
            T_CAPIR: return m ? T_EX1IR : T_SHIR;
            T_SHIR:  return m ? T_EX1IR : T_SHIR;
            T_EX1IR: return m ? T_UPDIR : T_PAUIR;
            T_PAUIR: return m ? T_EX2IR : T_PAUIR;
            T_EX2IR: return m ? T_UPDIR : T_SHIR;
            default: return m ? T_SELDR : T_RTI;
        endcase
    endfunction

    tap_e        tap = T_RTI;
    logic [3:0]  ir0 = IR_BYP, ir1 = IR_BYP, irs0 = '0, irs1 = '0;
    logic [31:0] dr0 = '0, dr1 = '0;
    logic        mid;
    int          shifts = 0, hi_run = 0, hi_max = 0;

    always @(posedge tck) begin
        if (tms) begin
            hi_run = hi_run + 1;
            if (hi_run > hi_max) hi_max = hi_run;
        end else begin
            hi_run = 0;
        end
        case (tap)
            T_TLR: begin ir0 = IR_ID; ir1 = IR_ID; end
            T_CAPDR: begin
                dr0 = (ir0 == IR_ID) ? ID0 : 32'd0;
                dr1 = (ir1 == IR_ID) ? ID1 : 32'd0;
            end
            T_SHDR: begin
                shifts = shifts + 1;
                mid = dr1[0];
                if (ir1 == IR_ID) dr1 = {tdi, dr1[31:1]}; else dr1[0] = tdi;
                if (ir0 == IR_ID) dr0 = {mid, dr0[31:1]}; else dr0[0] = mid;
            end
            T_CAPIR: begin irs0 = 4'b0001; irs1 = 4'b0001; end
            T_SHIR: begin
                shifts = shifts + 1;
                mid  = irs1[0];
                irs1 = {tdi, irs1[3:1]};
                irs0 = {mid, irs0[3:1]};
            end
            T_UPDIR: begin ir0 = irs0; ir1 = irs1; end
            default: ;
        endcase
        tap = tap_next(tap, tms);
    end

    always @(negedge tck) begin
        if (tap == T_SHDR)      tdo_m = dr0[0];
        else if (tap == T_SHIR) tdo_m = irs0[0];
        else                    tdo_m = 1'b0;
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops one expected word per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_cnt++;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: actual unexpected done expected none");
            end else begin
                automatic logic [63:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (rx_data !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, rx_data, e);
                end
            end
        end
    end

    // driver: push expected word, issue command, wait for completion
    task automatic run_cmd(input logic [1:0] op, input logic [6:0] len, input logic [63:0] tx,
                           input logic [63:0] exp, input string tag, input int exp_shifts);
        int start;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        shifts = 0; hi_max = 0; hi_run = 0;
        cmd_op = op; cmd_len = len; cmd_tx = tx; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 busy after take", {63'd0, busy}, 64'd1);
        start = done_cnt;
        for (int i = 0; i < 5000 && done_cnt == start; i++) @(negedge clk);
        check({tag, " chain back in Run-Test/Idle"}, 64'(tap), 64'(T_RTI));
        if (exp_shifts >= 0) check({tag, " shift count"}, 64'(shifts), 64'(exp_shifts));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs idle", {59'd0, busy, done, tck, tms, tdi}, 64'd0);
        check("R1 rx zero", rx_data, 64'd0);

        // R5 reset walk selects identification on both devices
        run_cmd(2'd0, 7'd8, 64'd0, 64'd0, "R5 reset", 0);
        check("R5 TMS high run", 64'(hi_max >= 5), 64'd1);
        check("R5 ident selected", {56'd0, ir1, ir0}, {56'd0, IR_ID, IR_ID});

        // R10 concatenated identifiers, R7 data scan, R8 64 bits
        run_cmd(2'd2, 7'd64, 64'd0, {ID1, ID0}, "R10 ident chain", 64);

        // R6 instruction scan: both bypass, capture pattern returned LSB first (R9)
        run_cmd(2'd1, 7'd8, 64'hFF, 64'h11, "R6 IR capture", 8);
        check("R6 bypass loaded", {56'd0, ir1, ir0}, {56'd0, IR_BYP, IR_BYP});

        // R10 two bypass bits delay the transmit word; R9 upper bits zero
        run_cmd(2'd2, 7'd10, 64'hF3, 64'h3CC, "R10 bypass delay", 10);

        // R8 single-bit scan, TMS high on its only bit
        run_cmd(2'd2, 7'd1, 64'h1, 64'h0, "R8 one bit", 1);

        // R9 select identification on device nearest TDO only
        run_cmd(2'd1, 7'd8, 64'hFE, 64'h11, "R9 IR load", 8);
        run_cmd(2'd2, 7'd33, 64'd0, {32'd0, ID0}, "R9 near ident", 33);

        // far device identified, near device bypassed
        run_cmd(2'd1, 7'd8, 64'hEF, 64'h11, "R9 IR load far", 8);
        fork
            run_cmd(2'd2, 7'd33, 64'd0, {32'd0, ID1} << 1, "R9 far ident", 33);
            begin : tck_period
                realtime t1, t2;
                @(posedge tck); t1 = $realtime;
                @(posedge tck); t2 = $realtime;
                check("R3 tck period ns", 64'(int'(t2 - t1)), 64'(2 * HALF * 20));
            end
        join

        // R2 command during busy is ignored
        fork
            run_cmd(2'd2, 7'd33, 64'd0, {32'd0, ID1} << 1, "R2 scan with stray cmd", 33);
            begin
                repeat (30) @(negedge clk);
                cmd_op = 2'd1; cmd_len = 7'd8; cmd_tx = 64'd0; cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        repeat (60) @(negedge clk);
        check("R2 IR untouched", {56'd0, ir1, ir0}, {56'd0, IR_ID, IR_BYP});
        check("R2 single done", 64'(exp_q.size()), 64'd0);
        // R11 result held after done
        check("R11 rx held", rx_data, {32'd0, ID1} << 1);

        // R7 op 3 acts as a data scan
        run_cmd(2'd3, 7'd33, 64'd0, {32'd0, ID1} << 1, "R7 alt op", 33);

        // R8 length 0 means 64 bits
        run_cmd(2'd0, 7'd8, 64'd0, 64'd0, "R5 reset again", 0);
        run_cmd(2'd2, 7'd0, 64'd0, {ID1, ID0}, "R8 zero length", 64);

        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule